// File: doc/BRIEF.md
# Memory Reference Ordering Matrix

This block tracks ordering hazards among four load/store units. Each pair of units has one dependency cell. When an operation is issued into a free unit, the block sets that unit's row against every occupied unit whose memory access must come first. A load waits on older stores. A store waits on older loads and older stores. Two loads never wait on each other. An atomic operation is issued with both the load and store flags raised, so it is ordered like a load and like a store at once.

A cell clears early in one case only. Both units must hold a generated address, both must be marked as considered in the current cycle, and the low-order address bits of the two units must differ. Cells whose addresses have not been generated stay set. A cell also clears when the older unit retires.

A unit is granted permission to go when it is occupied and its row holds no set cell. The address generator supplies only the low comparison bits of each address, because the block never compares any other bits.

Top module: `memdep_matrix`

## Requirements
- R1: After reset, no unit is occupied and every bit of `grant` is 0.
- R2: A load (issueLoad=1, issueStore=0) gains no dependency on occupied plain loads, so it is granted in the cycle after its issue edge when no store or atomic is occupied.
- R3: A load issued while an older store or atomic occupies a unit is not granted in the cycle after its issue edge.
- R4: A store (issueLoad=0, issueStore=1) issued while an older load, store or atomic occupies a unit is not granted until that dependency clears.
- R5: An atomic (issueLoad=1 and issueStore=1) waits on older loads and stores, and any younger load or store waits on the atomic.
- R6: When both units of a set cell hold generated addresses, both are set in `considerMask`, and their `agenLow` values differ, the cell clears at the next edge. The younger unit's grant rises after that edge if no other cell in its row is set.
- R7: A cell whose two units hold equal `agenLow` values is never cleared by the address test.
- R8: A cell stays set while either of its two units has not yet generated an address.
- R9: A cell stays set while either of its two units is clear in `considerMask`, even if the addresses differ.
- R10: Retiring a unit (its bit in `retireMask`) frees it, drops its grant after the edge, and clears every cell in which it is the older unit.
- R11: An operation issued into an otherwise empty block is granted in the cycle after its issue edge. A unit never depends on itself or on a younger unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| issueValid | input | 1 | An operation enters unit `issueUnit` this cycle |
| issueUnit | input | 2 | Index of the free unit being filled |
| issueLoad | input | 1 | Issued operation reads memory |
| issueStore | input | 1 | Issued operation writes memory (both flags set: atomic) |
| agenValid | input | 4 | Per unit, its address was generated this cycle |
| agenLow | input | 4x4 | Per unit, low comparison bits of the generated address |
| considerMask | input | 4 | Units being considered for forward progress this cycle |
| retireMask | input | 4 | Units completing and releasing their slot this cycle |
| grant | output | 4 | Per unit permission to perform its memory access |

## Verification
The checks assume a well-behaved issue stage. Issue targets only a free unit, at most one issue happens per cycle, `agenValid` pulses at most once per occupancy of an occupied unit, and a unit is retired only while it is granted, never in the same cycle it is issued. Under those assumptions, a set cell can only change through the address test or a retire. The stimulus is a set of directed sequences that each start from reset. Each issues into empty slots, generates each address once, and retires only units already seen granted, so every assumption holds throughout.

// File: rtl/memdep_pkg.sv
package memdep_pkg;

  localparam int MD_UNITS  = 4;
  localparam int MD_UNIT_W = $clog2(MD_UNITS);

  typedef logic [MD_UNITS-1:0] unitVec_t;

  // Strobes from control to datapath
  typedef struct packed {
    unitVec_t issued;
    unitVec_t retired;
  } mdStrobe_t;

  // Does a new operation need to wait on an older one?
  function automatic logic needsOrder(input logic newLd, input logic newSt,
                                      input logic oldLd, input logic oldSt);
    return (newSt && (oldLd || oldSt)) || (newLd && oldSt);
  endfunction

endpackage

// File: rtl/memdep_datapath.sv
module memdep_datapath
  import memdep_pkg::*;
#(
  parameter int CMP_W = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  mdStrobe_t                         strobes,
  input  logic [MD_UNITS-1:0]               agenValid,
  input  logic [MD_UNITS-1:0][CMP_W-1:0]    agenLow,
  input  logic [MD_UNITS-1:0]               considerMask,
  output logic [MD_UNITS-1:0][MD_UNITS-1:0] relax,
  output logic [MD_UNITS-1:0]               genFlag
);

  logic [MD_UNITS-1:0][CMP_W-1:0] lowAddr;
  logic [MD_UNITS-1:0]            genQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      genQ    <= '0;
      lowAddr <= '0;
    end else begin
      for (int u = 0; u < MD_UNITS; u++) begin
        if (strobes.issued[u] || strobes.retired[u]) begin
          genQ[u] <= 1'b0;
        end else if (agenValid[u]) begin
          genQ[u]    <= 1'b1;
          lowAddr[u] <= agenLow[u];
        end
      end
    end
  end

  // Pairwise clash test, gated by generation and consideration
  always_comb begin
    for (int i = 0; i < MD_UNITS; i++) begin
      for (int j = 0; j < MD_UNITS; j++) begin
        relax[i][j] = (i != j) && genQ[i] && genQ[j] &&
                      considerMask[i] && considerMask[j] &&
                      (lowAddr[i] != lowAddr[j]);
      end
    end
  end

  assign genFlag = genQ;

endmodule

// File: rtl/memdep_control.sv
module memdep_control
  import memdep_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              issueValid,
  input  logic [MD_UNIT_W-1:0]              issueUnit,
  input  logic                              issueLoad,
  input  logic                              issueStore,
  input  logic [MD_UNITS-1:0]               retireMask,
  input  logic [MD_UNITS-1:0][MD_UNITS-1:0] relax,
  output mdStrobe_t                         strobes,
  output logic [MD_UNITS-1:0]               occupied,
  output logic [MD_UNITS-1:0]               isStore,
  output logic [MD_UNITS-1:0][MD_UNITS-1:0] depMat,
  output logic [MD_UNITS-1:0]               grant
);

  logic [MD_UNITS-1:0]               issueHot;
  logic [MD_UNITS-1:0]               occQ;
  logic [MD_UNITS-1:0]               ldQ;
  logic [MD_UNITS-1:0]               stQ;
  logic [MD_UNITS-1:0][MD_UNITS-1:0] depQ;
  logic [MD_UNITS-1:0][MD_UNITS-1:0] depNext;

  always_comb begin
    issueHot = '0;
    if (issueValid) issueHot[issueUnit] = 1'b1;
  end

  always_comb begin
    strobes.issued  = issueHot;
    strobes.retired = retireMask;
  end

  // Row i: unit i waits on unit j
  always_comb begin
    for (int i = 0; i < MD_UNITS; i++) begin
      for (int j = 0; j < MD_UNITS; j++) begin
        if (issueHot[i]) begin
          depNext[i][j] = (i != j) && occQ[j] && !retireMask[j] &&
                          needsOrder(issueLoad, issueStore, ldQ[j], stQ[j]);
        end else begin
          depNext[i][j] = depQ[i][j] && !relax[i][j] && !retireMask[j] &&
                          !retireMask[i] && !issueHot[j];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      depQ <= '0;
      occQ <= '0;
      ldQ  <= '0;
      stQ  <= '0;
    end else begin
      depQ <= depNext;
      occQ <= (occQ | issueHot) & ~retireMask;
      for (int u = 0; u < MD_UNITS; u++) begin
        if (issueHot[u]) begin
          ldQ[u] <= issueLoad;
          stQ[u] <= issueStore;
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < MD_UNITS; i++) begin
      grant[i] = occQ[i] && (depQ[i] == '0);
    end
  end

  assign occupied = occQ;
  assign isStore  = stQ;
  assign depMat   = depQ;

endmodule

// File: rtl/memdep_matrix.sv
module memdep_matrix
  import memdep_pkg::*;
#(
  parameter int CMP_W = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           issueValid,
  input  logic [MD_UNIT_W-1:0]           issueUnit,
  input  logic                           issueLoad,
  input  logic                           issueStore,
  input  logic [MD_UNITS-1:0]            agenValid,
  input  logic [MD_UNITS-1:0][CMP_W-1:0] agenLow,
  input  logic [MD_UNITS-1:0]            considerMask,
  input  logic [MD_UNITS-1:0]            retireMask,
  output logic [MD_UNITS-1:0]            grant
);

  mdStrobe_t                         strobes;
  logic [MD_UNITS-1:0][MD_UNITS-1:0] relax;
  logic [MD_UNITS-1:0][MD_UNITS-1:0] depMat;
  logic [MD_UNITS-1:0]               genFlag;
  logic [MD_UNITS-1:0]               occupied;
  logic [MD_UNITS-1:0]               isStore;

  memdep_control ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .issueValid(issueValid),
    .issueUnit (issueUnit),
    .issueLoad (issueLoad),
    .issueStore(issueStore),
    .retireMask(retireMask),
    .relax     (relax),
    .strobes   (strobes),
    .occupied  (occupied),
    .isStore   (isStore),
    .depMat    (depMat),
    .grant     (grant)
  );

  memdep_datapath #(.CMP_W(CMP_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .agenValid   (agenValid),
    .agenLow     (agenLow),
    .considerMask(considerMask),
    .relax       (relax),
    .genFlag     (genFlag)
  );

endmodule

// File: rtl/memdep_checker.sv
module memdep_checker
  import memdep_pkg::*;
(
  input logic                              clk,
  input logic                              rstN,
  input logic                              issueValid,
  input logic [MD_UNIT_W-1:0]              issueUnit,
  input logic                              issueLoad,
  input logic                              issueStore,
  input logic [MD_UNITS-1:0]               considerMask,
  input logic [MD_UNITS-1:0]               retireMask,
  input logic [MD_UNITS-1:0]               grant,
  input logic [MD_UNITS-1:0]               occupied,
  input logic [MD_UNITS-1:0]               isStore,
  input logic [MD_UNITS-1:0][MD_UNITS-1:0] depMat,
  input logic [MD_UNITS-1:0]               genFlag
);

  // R11: issue into an empty block is granted at once
  assert_empty_issue_R11: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && ((occupied & ~retireMask) == '0)) |=> grant[$past(issueUnit)]);

  // R2: a plain load with no older writer is granted at once
  assert_load_no_writer_R2: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueLoad && !issueStore &&
     ((occupied & isStore & ~retireMask) == '0)) |=> grant[$past(issueUnit)]);

  // R3: a load behind a live writer must wait
  assert_load_waits_R3: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueLoad &&
     ((occupied & isStore & ~retireMask) != '0)) |=> !grant[$past(issueUnit)]);

  generate
    for (genvar i = 0; i < MD_UNITS; i++) begin : g_row
      // R10: a retired unit loses its grant
      assert_retire_drops_R10: assert property (@(posedge clk) disable iff (!rstN)
        retireMask[i] |=> !grant[i]);
      for (genvar j = 0; j < MD_UNITS; j++) begin : g_col
        // R8: no relax without both addresses generated
        assert_hold_ungen_R8: assert property (@(posedge clk) disable iff (!rstN)
          (depMat[i][j] && !(genFlag[i] && genFlag[j]) &&
           !retireMask[i] && !retireMask[j]) |=> depMat[i][j]);
        // R9: no relax unless both units are considered
        assert_hold_unconsidered_R9: assert property (@(posedge clk) disable iff (!rstN)
          (depMat[i][j] && !(considerMask[i] && considerMask[j]) &&
           !retireMask[i] && !retireMask[j]) |=> depMat[i][j]);
      end
    end
  endgenerate

endmodule

bind memdep_matrix memdep_checker chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .issueValid  (issueValid),
  .issueUnit   (issueUnit),
  .issueLoad   (issueLoad),
  .issueStore  (issueStore),
  .considerMask(considerMask),
  .retireMask  (retireMask),
  .grant       (grant),
  .occupied    (occupied),
  .isStore     (isStore),
  .depMat      (depMat),
  .genFlag     (genFlag)
);

// File: tb/memdep_matrix_tb_top.sv
module memdep_matrix_tb_top;
  import memdep_pkg::*;

  localparam int CMP_W = 4;

  logic                           clk = 1'b0;
  logic                           rstN = 1'b0;
  logic                           issueValid = 1'b0;
  logic [MD_UNIT_W-1:0]           issueUnit = '0;
  logic                           issueLoad = 1'b0;
  logic                           issueStore = 1'b0;
  logic [MD_UNITS-1:0]            agenValid = '0;
  logic [MD_UNITS-1:0][CMP_W-1:0] agenLow = '0;
  logic [MD_UNITS-1:0]            considerMask = '0;
  logic [MD_UNITS-1:0]            retireMask = '0;
  logic [MD_UNITS-1:0]            grant;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  typedef struct {
    logic [MD_UNITS-1:0] g;
    string               tag;
  } exp_t;
  exp_t expQ[$];

  always #4 clk = ~clk;  // 8 ns period

  memdep_matrix #(.CMP_W(CMP_W)) dut_i (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueUnit(issueUnit),
    .issueLoad(issueLoad), .issueStore(issueStore), .agenValid(agenValid),
    .agenLow(agenLow), .considerMask(considerMask), .retireMask(retireMask),
    .grant(grant)
  );

  // Monitor: compare grant against queued expectations
  always @(negedge clk) begin
    while (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      checks++;
      if (grant !== e.g) begin
        fails++;
        $display("FAIL %s: grant=%b expected=%b", e.tag, grant, e.g);
      end
    end
  end

  task automatic clearPulses();
    issueValid = 1'b0;
    issueLoad  = 1'b0;
    issueStore = 1'b0;
    agenValid  = '0;
    retireMask = '0;
  endtask

  // Driver: apply one edge, then queue the grant expected after it
  task automatic step(input logic [MD_UNITS-1:0] g, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    e.g = g;
    e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    clearPulses();
  endtask

  task automatic doReset();
    rstN = 1'b0;
    clearPulses();
    considerMask = '0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic issue(input int u, input logic ld, input logic st);
    issueValid = 1'b1;
    issueUnit  = MD_UNIT_W'(u);
    issueLoad  = ld;
    issueStore = st;
  endtask

  task automatic setAgen(input int u, input logic [CMP_W-1:0] a);
    agenValid[u] = 1'b1;
    agenLow[u]   = a;
  endtask

  task automatic retireU(input int u);
    retireMask[u] = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // Scenario A: load behind store with matching low bits
    doReset();
    step(4'b0000, "R1 reset state");
    considerMask = 4'b1111;
    issue(0, 1'b0, 1'b1);  step(4'b0001, "R11 store into empty block");
    issue(1, 1'b1, 1'b0);  step(4'b0001, "R3 load behind store waits");
    setAgen(0, 4'h4); setAgen(1, 4'h4);
    step(4'b0001, "R7 address capture edge");
    step(4'b0001, "R7 equal low bits hold");
    step(4'b0001, "R7 equal low bits still hold");
    retireU(0);            step(4'b0010, "R10 retire releases load, drops own grant");

    // Scenario B: mismatch relax gated by consideration
    doReset();
    issue(2, 1'b0, 1'b1);  step(4'b0100, "R11 store into empty block");
    issue(3, 1'b1, 1'b0);  step(4'b0100, "R3 load behind store waits");
    setAgen(2, 4'h0); setAgen(3, 4'h3);
    step(4'b0100, "R9 nothing considered");
    considerMask = 4'b0100;
    step(4'b0100, "R9 younger unit not considered");
    considerMask = 4'b1100;
    step(4'b1100, "R6 mismatch relaxes load");

    // Scenario C: loads, stores, and an ungenerated older store
    doReset();
    considerMask = 4'b1111;
    issue(0, 1'b1, 1'b0);  step(4'b0001, "R11 load into empty block");
    issue(1, 1'b1, 1'b0);  step(4'b0011, "R2 load behind load proceeds");
    issue(2, 1'b0, 1'b1);  step(4'b0011, "R4 store behind loads waits");
    retireU(0);            step(4'b0010, "R10 store still waits on second load");
    retireU(1);            step(4'b0100, "R10 store released");
    issue(0, 1'b0, 1'b1);  step(4'b0100, "R4 store behind store waits");
    setAgen(0, 4'h5);      step(4'b0100, "R8 only younger generated");
    step(4'b0100, "R8 older address never generated");

    // Scenario D: atomic ordering
    doReset();
    considerMask = 4'b1111;
    issue(1, 1'b1, 1'b0);  step(4'b0010, "R11 load into empty block");
    issue(2, 1'b1, 1'b1);  step(4'b0010, "R5 atomic waits on load");
    issue(3, 1'b1, 1'b0);  step(4'b0010, "R5 load waits on atomic");
    retireU(1);            step(4'b0100, "R5 atomic released");
    retireU(2);            step(4'b1000, "R5 load released after atomic");

    @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule